// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Cross-Port Collision Flagging

This block is a synchronous memory with two fully independent access ports on one shared clock. Each port has an enable, a write strobe, an address and a write-data bus. It also has a registered read-data bus and a registered collision flag. Read data appears one clock after the address is sampled. Each port's behaviour on its own write is set by a parameter. It can return the data just written, return the word the location held before the write, or leave its output unchanged.

The block covers one case that a plain memory model leaves undefined. One port may write a location while the other port accesses that same location in the same cycle. The write still lands in the array. The other port's output for that cycle is replaced by a parameterised poison word, and its collision flag is raised, so nothing downstream takes it as valid data. If the reading port asks for the same address again on the next cycle, it receives the new word. The collision therefore costs the reader one extra cycle. When both ports write the same location in the same cycle, port A's data is kept and both ports report a collision.

Top module: `tdp_ram_collide`

## Requirements
- R1: With a port enabled and its write strobe low, and no collision, that port's read data on the following cycle equals the word stored at the sampled address.
- R2: A port configured for write-first (mode code 0) that writes without collision shows the written data on its read bus on the following cycle.
- R3: A port configured for read-first (mode code 1) that writes without collision shows the word the location held before the write on the following cycle, and the array takes the new data.
- R4: A port configured for no-change (mode code 2) that writes without collision keeps its read bus at its previous value.
- R5: When port X writes an address that port Y accesses in the same cycle, the write still reaches the array, and a later read of that address returns the new word.
- R6: A port whose enabled access collides with a write by the other port to the same address shows the POISON word and a raised collision flag on the next cycle. This does not depend on its own write mode.
- R7: The collision flag of a port is low on the cycle after any enabled access without collision.
- R8: When both ports write the same address in the same cycle, port A's data is stored, and both ports show POISON with flags raised on the next cycle.
- R9: A disabled port performs no write, keeps its read data and shows a low collision flag.
- R10: While reset is asserted and directly after it, both read buses are zero and both collision flags are low. Array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of outputs and flags |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| a_coll | output | 1 | Port A collision flag for the current read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| b_coll | output | 1 | Port B collision flag for the current read data |

## Verification
The hardest situation to bring about is a collision at every address in both directions. Each collision must be followed at once by a clean re-read, so that the poisoned cycle and the recovered data are both seen. The bench sweeps every address of a 16-entry array. It drives a write on one port and a read on the other to the same address, then re-reads on the next cycle. It then repeats the sweep with the roles swapped and with both ports writing. Two instances share the stimulus: one has write-first on A and read-first on B, the other has no-change on both ports. This confirms that the collision result does not depend on the reading port's mode.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    // Write-time behaviour of a port's read bus
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

endpackage

// File: rtl/tdp_array.sv
module tdp_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_word,
    output logic [DATA_W-1:0] b_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];

    // One storage row per address; port A wins a same-row double write
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic              a_sel;
        logic              b_sel;
        logic [DATA_W-1:0] row_d;

        always_comb begin
            a_sel = a_wr && (a_addr == ADDR_W'(g));
            b_sel = b_wr && (b_addr == ADDR_W'(g));
            row_d = word_q[g];
            if (a_sel) begin
                row_d = a_wdata;
            end else if (b_sel) begin
                row_d = b_wdata;
            end
        end

        always_ff @(posedge clk) begin
            word_q[g] <= row_d;
        end
    end

    // Pre-write contents seen by the port output stages
    assign a_word = word_q[a_addr];
    assign b_word = word_q[b_addr];

    AST_A_WINS_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && b_wr && a_addr == b_addr) |=> (word_q[$past(a_addr)] == $past(a_wdata))); // R8

    AST_B_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && !(a_wr && a_addr == b_addr)) |=> (word_q[$past(b_addr)] == $past(b_wdata))); // R5

endmodule

// File: rtl/tdp_collide.sv
module tdp_collide #(
    parameter int ADDR_W = 8
) (
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_hit,
    output logic              b_hit
);
    logic same_row;

    always_comb begin
        same_row = (a_addr == b_addr);
        // A port is hit when the other port writes the row it touches
        a_hit = a_en && b_en && b_we && same_row;
        b_hit = b_en && a_en && a_we && same_row;
    end

endmodule

// File: rtl/tdp_port.sv
module tdp_port #(
    parameter int              DATA_W = 32,
    parameter tdp_pkg::wmode_e MODE   = tdp_pkg::WM_WRITE_FIRST,
    parameter logic [DATA_W-1:0] POISON = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] word,
    input  logic              hit,
    output logic [DATA_W-1:0] rdata,
    output logic              coll
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              flag;
    } out_st_t;

    out_st_t           out_d;
    out_st_t           out_q;
    logic [DATA_W-1:0] wr_view;

    // Read-bus value on a clean write, picked by the configured mode
    if (MODE == tdp_pkg::WM_WRITE_FIRST) begin : g_wf
        assign wr_view = wdata;
    end else if (MODE == tdp_pkg::WM_READ_FIRST) begin : g_rf
        assign wr_view = word;
    end else begin : g_nc
        assign wr_view = out_q.data;
    end

    always_comb begin
        out_d      = out_q;
        out_d.flag = 1'b0;
        if (en) begin
            if (hit) begin
                out_d.data = POISON;
                out_d.flag = 1'b1;
            end else if (we) begin
                out_d.data = wr_view;
            end else begin
                out_d.data = word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata = out_q.data;
    assign coll  = out_q.flag;

    AST_POISON_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        coll |-> (rdata == POISON)); // R6
    AST_FLAG_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit) |=> coll); // R6
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we && !hit) |=> (rdata == $past(word) && !coll)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(rdata) && !coll)); // R9

    if (MODE == tdp_pkg::WM_WRITE_FIRST) begin : g_chk_wf
        AST_WRITE_FIRST_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
            (en && we && !hit) |=> (rdata == $past(wdata))); // R2
    end else if (MODE == tdp_pkg::WM_READ_FIRST) begin : g_chk_rf
        AST_READ_FIRST_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            (en && we && !hit) |=> (rdata == $past(word))); // R3
    end else begin : g_chk_nc
        AST_NO_CHANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (en && we && !hit) |=> $stable(rdata)); // R4
    end

endmodule

// File: rtl/tdp_ram_collide.sv
module tdp_ram_collide #(
    parameter int                ADDR_W = 8,
    parameter int                DATA_W = 32,
    parameter tdp_pkg::wmode_e   MODE_A = tdp_pkg::WM_WRITE_FIRST,
    parameter tdp_pkg::wmode_e   MODE_B = tdp_pkg::WM_WRITE_FIRST,
    parameter logic [DATA_W-1:0] POISON = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_coll,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_coll
);
    logic [DATA_W-1:0] a_word;
    logic [DATA_W-1:0] b_word;
    logic              a_hit;
    logic              b_hit;

    tdp_collide #(.ADDR_W(ADDR_W)) u_collide (
        .a_en   (a_en),
        .a_we   (a_we),
        .a_addr (a_addr),
        .b_en   (b_en),
        .b_we   (b_we),
        .b_addr (b_addr),
        .a_hit  (a_hit),
        .b_hit  (b_hit)
    );

    tdp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_wr    (a_en && a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .b_wr    (b_en && b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .a_word  (a_word),
        .b_word  (b_word)
    );

    tdp_port #(.DATA_W(DATA_W), .MODE(MODE_A), .POISON(POISON)) u_port_a (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (a_en),
        .we    (a_we),
        .wdata (a_wdata),
        .word  (a_word),
        .hit   (a_hit),
        .rdata (a_rdata),
        .coll  (a_coll)
    );

    tdp_port #(.DATA_W(DATA_W), .MODE(MODE_B), .POISON(POISON)) u_port_b (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (b_en),
        .we    (b_we),
        .wdata (b_wdata),
        .word  (b_word),
        .hit   (b_hit),
        .rdata (b_rdata),
        .coll  (b_coll)
    );

    AST_DOUBLE_WRITE_BOTH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && b_en && b_we && a_addr == b_addr) |=> (a_coll && b_coll)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (a_rdata == '0 && b_rdata == '0 && !a_coll && !b_coll)); // R10

endmodule

// File: tb/tdp_ram_collide_test.sv
module tdp_ram_collide_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 4;
    localparam int          DW         = 16;
    localparam int          DEPTH      = 1 << AW;
    localparam logic [15:0] POISON     = 16'hBAD0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] rd [2][2];
    logic          fl [2][2];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // mode code per instance and port: 0 write-first, 1 read-first, 2 no-change
    int mode_of [2][2] = '{'{0, 1}, '{2, 2}};

    logic [DW-1:0] refm [DEPTH];
    logic [DW-1:0] exp_d [2][2];

    always #(CLK_PERIOD/2) clk = ~clk;

    tdp_ram_collide #(.ADDR_W(AW), .DATA_W(DW),
        .MODE_A(tdp_pkg::WM_WRITE_FIRST), .MODE_B(tdp_pkg::WM_READ_FIRST),
        .POISON(POISON)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(rd[0][0]), .a_coll(fl[0][0]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(rd[0][1]), .b_coll(fl[0][1]));

    tdp_ram_collide #(.ADDR_W(AW), .DATA_W(DW),
        .MODE_A(tdp_pkg::WM_NO_CHANGE), .MODE_B(tdp_pkg::WM_NO_CHANGE),
        .POISON(POISON)) uut_nc (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(rd[1][0]), .a_coll(fl[1][0]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(rd[1][1]), .b_coll(fl[1][1]));

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    // Drive one cycle at a falling edge, predict, then compare at the next falling edge
    task automatic step(input logic ea, input logic wa, input int aa, input logic [DW-1:0] da,
                        input logic eb, input logic wb, input int ab, input logic [DW-1:0] db,
                        input string rtag);
        logic          en [2];
        logic          we [2];
        int            ad [2];
        logic [DW-1:0] wd [2];
        logic          hit [2];
        logic          ww;
        string         dtag [2][2];
        string         ftag [2];
        a_en = ea; a_we = wa; a_addr = AW'(aa); a_wdata = da;
        b_en = eb; b_we = wb; b_addr = AW'(ab); b_wdata = db;
        en[0] = ea; we[0] = wa; ad[0] = aa; wd[0] = da;
        en[1] = eb; we[1] = wb; ad[1] = ab; wd[1] = db;
        ww = ea && wa && eb && wb && (aa == ab);
        hit[0] = ea && eb && wb && (aa == ab);
        hit[1] = eb && ea && wa && (aa == ab);
        for (int p = 0; p < 2; p++) begin
            if (!en[p])     ftag[p] = "R9";
            else if (ww)    ftag[p] = "R8";
            else if (hit[p]) ftag[p] = "R6";
            else            ftag[p] = "R7";
            for (int i = 0; i < 2; i++) begin
                if (!en[p]) begin
                    dtag[i][p] = "R9";
                end else if (hit[p]) begin
                    exp_d[i][p] = POISON;
                    dtag[i][p]  = ww ? "R8" : "R6";
                end else if (we[p]) begin
                    case (mode_of[i][p])
                        0:       begin exp_d[i][p] = wd[p];        dtag[i][p] = "R2"; end
                        1:       begin exp_d[i][p] = refm[ad[p]];  dtag[i][p] = "R3"; end
                        default: begin                             dtag[i][p] = "R4"; end
                    endcase
                end else begin
                    exp_d[i][p] = refm[ad[p]];
                    dtag[i][p]  = rtag;
                end
            end
        end
        if (ea && wa) refm[aa] = da;
        if (eb && wb && !(ea && wa && aa == ab)) refm[ab] = db;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            for (int p = 0; p < 2; p++) begin
                check(dtag[i][p], rd[i][p], exp_d[i][p]);
                check(ftag[p], DW'(fl[i][p]), DW'(hit[p]));
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2; i++)
            for (int p = 0; p < 2; p++)
                exp_d[i][p] = '0;
        repeat (3) @(negedge clk);
        // R10: reset values held during and right after reset
        for (int i = 0; i < 2; i++)
            for (int p = 0; p < 2; p++) begin
                check("R10", rd[i][p], '0);
                check("R10", DW'(fl[i][p]), '0);
            end
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++)
            for (int p = 0; p < 2; p++) begin
                check("R10", rd[i][p], '0);
                check("R10", DW'(fl[i][p]), '0);
            end

        // Fill every row through port A (R2 echo, R4 hold, R9 idle B)
        for (int a = 0; a < DEPTH; a++)
            step(1, 1, a, DW'(16'h1000 + a * 257), 0, 0, 0, '0, "R1");
        // R1: concurrent reads on both ports at distinct rows
        for (int a = 0; a < DEPTH; a++)
            step(1, 0, a, '0, 1, 0, DEPTH - 1 - a, '0, "R1");
        // R2/R4 on A, then read back through B
        for (int a = 0; a < DEPTH; a++) begin
            step(1, 1, a, DW'(16'h2000 + a * 3), 0, 0, 0, '0, "R1");
            step(0, 0, 0, '0, 1, 0, a, '0, "R1");
        end
        // R3 read-first on B, then read back through A
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 0, 0, '0, 1, 1, a, DW'(16'h3000 + a * 5), "R1");
            step(1, 0, a, '0, 0, 0, 0, '0, "R3");
        end
        // R6 then R5: A writes, B reads same row, B re-reads
        for (int a = 0; a < DEPTH; a++) begin
            step(1, 1, a, DW'(16'h4000 + a * 7), 1, 0, a, '0, "R1");
            step(0, 0, 0, '0, 1, 0, a, '0, "R5");
        end
        // R6 then R5 the other way round
        for (int a = 0; a < DEPTH; a++) begin
            step(1, 0, a, '0, 1, 1, a, DW'(16'h5000 + a * 11), "R1");
            step(1, 0, a, '0, 0, 0, 0, '0, "R5");
        end
        // R8: double write to one row, A's word must remain
        for (int a = 0; a < DEPTH; a++) begin
            step(1, 1, a, DW'(16'h6000 + a), 1, 1, a, DW'(16'h7000 + a), "R1");
            step(1, 0, a, '0, 1, 0, a, '0, "R8");
        end
        // Writes on both ports to different rows, no collision
        for (int a = 0; a < DEPTH; a++) begin
            step(1, 1, a, DW'(16'h0800 + a), 1, 1, (a + 1) % DEPTH, DW'(16'h0900 + a), "R1");
            step(1, 0, a, '0, 1, 0, (a + 1) % DEPTH, '0, "R1");
        end
        // R9: write strobes with enables low leave rows and outputs untouched
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 1, a, 16'hEEEE, 0, 1, a, 16'hDDDD, "R1");
            step(1, 0, a, '0, 1, 0, a, '0, "R9");
        end
        finish_run();
    end

endmodule